// File: doc/BRIEF.md
# CPU Clock Source Selector with Deferred Switching

This block produces the CPU clock enable (Φ) from two sources. The first is a fast main oscillator, which is the block's own clock. The second is a slow subsystem oscillator that arrives as a free-running level. On the main source, Φ is a one-cycle pulse at fX/64, fX/16, fX/8 or fX/4, chosen by a 2-bit divider code. On the subsystem source, Φ pulses once per rising edge of the subsystem oscillator. One machine cycle is one Φ period.

A write to the control port does not change the selection at once. The block goes on running on the old Φ and counts a switch delay. The length of that delay depends on the committed selection and on the requested one. When the count runs out, the new selection is committed. The block rejects one illegal combination: the subsystem source together with the fX/16 code. It can also stop the main oscillator, either through a committed control bit or through a stop request. The stop request is honoured only when no switch is pending.

Top module: `phi_clock_selector`

## Requirements
- R1: After synchronous reset, the outputs are as follows: the divider code is 00, the source is main, main_osc_en is 1, busy is 0 and err_flag is 0.
- R2: On the main source, with the oscillator running, phi_en pulses every 64, 16, 8 or 4 clocks. Divider codes 00, 01, 10 and 11 select these rates in that order.
- R3: A legal write sets busy in the following cycle. cur_div and cur_sub keep their old values until the cycle in which busy falls.
- R4: A switch between main-source codes lasts 1 old Φ pulse when the new code is equal to or faster than the old one. It lasts 4, 8 or 16 old Φ pulses when the new code is 1, 2 or 3 steps slower.
- R5: A switch from the main source to the subsystem source commits after SUB_TICKS synchronised subsystem rising edges (default 3). Any switch that starts from the subsystem source lasts 1 Φ pulse.
- R6: On the subsystem source, phi_en pulses once for each rising edge of sub_osc, after a two-flop synchroniser.
- R7: A write with wr_sub=1 and wr_div=01 is dropped. Any pending switch and the committed selection stay unchanged. err_flag goes to 1 and stays at 1 until reset. The committed selection never pairs the subsystem source with code 01.
- R8: A legal write made while busy restarts the delay with the newest request. The new delay is measured from the committed selection.
- R9: Main-oscillator control follows four rules:
  - A committed wr_osc_off=1 clears main_osc_en.
  - stop_req clears main_osc_en when busy is 0.
  - stop_req has no effect while busy is 1.
  - A legal write with wr_osc_off=0 sets main_osc_en in the following cycle.
  While main_osc_en is 0 on the main source, phi_en stays low.
- R10: phi_en is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_osc | input | 1 | Subsystem oscillator level, asynchronous |
| wr_en | input | 1 | Control write strobe |
| wr_div | input | 2 | Requested divider code |
| wr_sub | input | 1 | Requested source, 1 = subsystem |
| wr_osc_off | input | 1 | Request to stop the main oscillator at commit |
| stop_req | input | 1 | Stop request for the main oscillator |
| phi_en | output | 1 | CPU clock enable pulse |
| cur_div | output | 2 | Committed divider code |
| cur_sub | output | 1 | Committed source |
| busy | output | 1 | A switch is pending |
| err_flag | output | 1 | Sticky illegal-write flag |
| main_osc_en | output | 1 | Main oscillator running |

## Verification
The divider is tested by moving from the slowest code to the fastest and back again, and by stepping one code at a time. This separates the 1-cycle delay from the 4-, 8- and 16-cycle delays, and measures each resulting Φ period. Source changes are tested in both directions:
- main to subsystem, which counts subsystem edges;
- subsystem to main, which counts a single Φ pulse.
A second write during a long delay shows that the count restarts rather than continuing from where it was. The illegal pattern and the stop requests are applied both while idle and while a switch is pending, which separates the dropped request from the honoured one.

// File: rtl/phi_sel_pkg.sv
package phi_sel_pkg;

  typedef logic [1:0] div_code_t;

  localparam div_code_t DIV_F16 = 2'b01;

  // Main-clock divisor for a divider code.
  function automatic int unsigned div_ratio(div_code_t c);
    if (c == 2'b00) return 64;
    return 32 >> c;
  endfunction

  // Switch delay in old-phi pulses between two main-clock codes.
  function automatic int unsigned switch_len(div_code_t o, div_code_t n);
    if (n >= o) return 1;
    return 4 << (o - n - 2'd1);
  endfunction

endpackage

// File: rtl/phi_sub_sync.sv
module phi_sub_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sub_osc,
  output logic sub_pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      sub_pulse <= 1'b0;
    end else begin
      sh        <= {sh[STAGES-1:0], sub_osc};
      sub_pulse <= sh[STAGES-1] & ~sh[STAGES];
    end
  end
endmodule

// File: rtl/phi_main_div.sv
module phi_main_div
  import phi_sel_pkg::*;
#(
  parameter int MAX_RATIO = 64,
  localparam int CW = $clog2(MAX_RATIO)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      restart,
  input  div_code_t code,
  output logic      pulse
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb last = CW'(div_ratio(code) - 1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == last) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/phi_switch_ctrl.sv
module phi_switch_ctrl
  import phi_sel_pkg::*;
#(
  parameter int SUB_TICKS = 3,
  localparam int MAXD = (SUB_TICKS > 16) ? SUB_TICKS : 16,
  localparam int DW = $clog2(MAXD + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  div_code_t wr_div,
  input  logic      wr_sub,
  input  logic      wr_osc_off,
  input  logic      stop_req,
  input  logic      phi_tick,
  input  logic      sub_tick,
  output div_code_t cur_div,
  output logic      cur_sub,
  output logic      busy,
  output logic      err_flag,
  output logic      main_run,
  output logic      commit_now
);
  div_code_t     pend_div;
  logic          pend_sub, pend_off, by_sub;
  logic [DW-1:0] cnt, new_len;
  logic          illegal, wr_ok, tick;

  always_comb begin
    illegal    = wr_sub && (wr_div == DIV_F16);
    wr_ok      = wr_en && !illegal;
    tick       = by_sub ? sub_tick : phi_tick;
    commit_now = !wr_ok && busy && tick && (cnt == DW'(1));
    if (!cur_sub && wr_sub)       new_len = DW'(SUB_TICKS);
    else if (!cur_sub && !wr_sub) new_len = DW'(switch_len(cur_div, wr_div));
    else                          new_len = DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_div  <= 2'b00;
      cur_sub  <= 1'b0;
      pend_div <= 2'b00;
      pend_sub <= 1'b0;
      pend_off <= 1'b0;
      by_sub   <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      err_flag <= 1'b0;
      main_run <= 1'b1;
    end else begin
      if (wr_en && illegal) err_flag <= 1'b1;
      if (wr_ok) begin
        pend_div <= wr_div;
        pend_sub <= wr_sub;
        pend_off <= wr_osc_off;
        by_sub   <= !cur_sub && wr_sub;
        cnt      <= new_len;
        busy     <= 1'b1;
        if (!wr_osc_off) main_run <= 1'b1;
      end else if (commit_now) begin
        cur_div <= pend_div;
        cur_sub <= pend_sub;
        busy    <= 1'b0;
        if (pend_off) main_run <= 1'b0;
      end else if (busy && tick) begin
        cnt <= cnt - 1'b1;
      end else if (!busy && stop_req) begin
        main_run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phi_clock_selector.sv
module phi_clock_selector
  import phi_sel_pkg::*;
#(
  parameter int SUB_TICKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sub_osc,
  input  logic       wr_en,
  input  logic [1:0] wr_div,
  input  logic       wr_sub,
  input  logic       wr_osc_off,
  input  logic       stop_req,
  output logic       phi_en,
  output logic [1:0] cur_div,
  output logic       cur_sub,
  output logic       busy,
  output logic       err_flag,
  output logic       main_osc_en
);
  logic sub_pulse, div_pulse, commit_now;

  phi_sub_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sub_osc(sub_osc), .sub_pulse(sub_pulse)
  );

  phi_main_div #(.MAX_RATIO(64)) u_div (
    .clk(clk), .rst(rst), .run(main_osc_en), .restart(commit_now),
    .code(cur_div), .pulse(div_pulse)
  );

  phi_switch_ctrl #(.SUB_TICKS(SUB_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_div(wr_div), .wr_sub(wr_sub),
    .wr_osc_off(wr_osc_off), .stop_req(stop_req), .phi_tick(phi_en),
    .sub_tick(sub_pulse), .cur_div(cur_div), .cur_sub(cur_sub), .busy(busy),
    .err_flag(err_flag), .main_run(main_osc_en), .commit_now(commit_now)
  );

  always_ff @(posedge clk) begin
    if (rst) phi_en <= 1'b0;
    else     phi_en <= cur_sub ? sub_pulse : div_pulse;
  end
endmodule

// File: rtl/phi_clock_selector_chk.sv
module phi_clock_selector_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_div,
  input logic       wr_sub,
  input logic       stop_req,
  input logic       phi_en,
  input logic [1:0] cur_div,
  input logic       cur_sub,
  input logic       busy,
  input logic       err_flag,
  input logic       main_osc_en
);
  AST_PHI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    phi_en |=> !phi_en); // R10
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en && !(wr_sub && wr_div == 2'b01) |=> busy); // R3
  AST_SEL_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cur_div) || !$stable(cur_sub)) |-> $fell(busy)); // R3
  AST_ILLEGAL_DROP: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sub && wr_div == 2'b01 && !busy |=>
      err_flag && !busy && $stable(cur_div) && $stable(cur_sub)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R7
  AST_NO_SUB_F16: assert property (@(posedge clk) disable iff (rst)
    cur_sub |-> cur_div != 2'b01); // R7
  AST_OSC_STOP_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(main_osc_en) |-> ($fell(busy) || ($past(stop_req) && !$past(busy)))); // R9
endmodule

bind phi_clock_selector phi_clock_selector_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_div(wr_div), .wr_sub(wr_sub),
  .stop_req(stop_req), .phi_en(phi_en), .cur_div(cur_div), .cur_sub(cur_sub),
  .busy(busy), .err_flag(err_flag), .main_osc_en(main_osc_en)
);

// File: tb/test_phi_clock_selector.sv
module test_phi_clock_selector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sub_osc = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_div = 2'b00;
  logic       wr_sub = 1'b0;
  logic       wr_osc_off = 1'b0;
  logic       stop_req = 1'b0;
  logic       phi_en, cur_sub, busy, err_flag, main_osc_en;
  logic [1:0] cur_div;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam int SUB_HALF = 16;

  phi_clock_selector i_phi_clock_selector (
    .clk(clk), .rst(rst), .sub_osc(sub_osc), .wr_en(wr_en), .wr_div(wr_div),
    .wr_sub(wr_sub), .wr_osc_off(wr_osc_off), .stop_req(stop_req),
    .phi_en(phi_en), .cur_div(cur_div), .cur_sub(cur_sub), .busy(busy),
    .err_flag(err_flag), .main_osc_en(main_osc_en)
  );

  always #4 clk = ~clk;
  always #(8 * SUB_HALF) sub_osc = ~sub_osc;

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic do_write(logic [1:0] d, logic s, logic off);
    @(negedge clk);
    wr_en = 1'b1; wr_div = d; wr_sub = s; wr_osc_off = off;
    @(negedge clk);
    wr_en = 1'b0; wr_sub = 1'b0; wr_osc_off = 1'b0;
  endtask

  // Counts phi pulses seen while busy, starting at the current negedge.
  task automatic count_delay(output int n);
    int guard = 0;
    n = 0;
    while (busy && guard < 5000) begin
      if (phi_en) n++;
      @(negedge clk);
      guard++;
    end
  endtask

  // Measures the phi period and checks that each pulse lasts one cycle.
  task automatic measure_period(output int p);
    int guard = 0;
    p = 0;
    @(negedge clk);
    while (!phi_en && guard < 500) begin @(negedge clk); guard++; end
    @(negedge clk);
    p = 1;
    check("R10 pulse width", int'(phi_en), 0);
    while (!phi_en && p < 500) begin @(negedge clk); p++; end
  endtask

  task automatic t_reset();
    int p;
    check("R1 cur_div", int'(cur_div), 0);
    check("R1 cur_sub", int'(cur_sub), 0);
    check("R1 main_osc_en", int'(main_osc_en), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 err_flag", int'(err_flag), 0);
    measure_period(p);
    check("R2 period code 00", p, 64);
  endtask

  task automatic t_main_steps();
    int n, p;
    do_write(2'b11, 1'b0, 1'b0);
    check("R3 busy after write", int'(busy), 1);
    check("R3 cur_div held", int'(cur_div), 0);
    count_delay(n);
    check("R4 delay 00->11", n, 1);
    check("R4 cur_div 11", int'(cur_div), 3);
    measure_period(p);
    check("R2 period code 11", p, 4);
    do_write(2'b00, 1'b0, 1'b0);
    count_delay(n);
    check("R4 delay 11->00", n, 16);
    do_write(2'b10, 1'b0, 1'b0);
    count_delay(n);
    check("R4 delay 00->10", n, 1);
    measure_period(p);
    check("R2 period code 10", p, 8);
    do_write(2'b01, 1'b0, 1'b0);
    count_delay(n);
    check("R4 delay 10->01", n, 4);
    measure_period(p);
    check("R2 period code 01", p, 16);
  endtask

  task automatic t_illegal();
    int p;
    do_write(2'b01, 1'b1, 1'b0);
    check("R7 busy stays low", int'(busy), 0);
    check("R7 err_flag set", int'(err_flag), 1);
    check("R7 cur_sub kept", int'(cur_sub), 0);
    check("R7 cur_div kept", int'(cur_div), 1);
    measure_period(p);
    check("R7 period unchanged", p, 16);
    check("R7 err_flag sticky", int'(err_flag), 1);
  endtask

  task automatic t_restart();
    int n, guard;
    do_write(2'b00, 1'b0, 1'b0);
    guard = 0;
    while (!phi_en && guard < 200) begin @(negedge clk); guard++; end
    do_write(2'b11, 1'b0, 1'b0);
    count_delay(n);
    check("R8 restarted delay 01->11", n, 1);
    check("R8 newest value", int'(cur_div), 3);
  endtask

  task automatic t_sub_path();
    int n, p;
    do_write(2'b10, 1'b1, 1'b0);
    check("R3 cur_sub held", int'(cur_sub), 0);
    count_delay(n);
    check("R5 on subsystem", int'(cur_sub), 1);
    check("R5 cur_div 10", int'(cur_div), 2);
    measure_period(p);
    check("R6 period from sub edges", p, 2 * SUB_HALF);
    do_write(2'b10, 1'b1, 1'b1);
    count_delay(n);
    check("R5 delay from subsystem", n, 1);
    check("R9 osc off committed", int'(main_osc_en), 0);
    measure_period(p);
    check("R6 period with main off", p, 2 * SUB_HALF);
    do_write(2'b00, 1'b0, 1'b0);
    check("R9 osc restart on write", int'(main_osc_en), 1);
    count_delay(n);
    check("R5 delay sub->main", n, 1);
    check("R5 back on main", int'(cur_sub), 0);
    measure_period(p);
    check("R2 period after return", p, 64);
  endtask

  task automatic t_stop();
    int n, seen;
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R9 stop when idle", int'(main_osc_en), 0);
    seen = 0;
    repeat (150) begin @(negedge clk); if (phi_en) seen++; end
    check("R9 no phi while stopped", seen, 0);
    do_write(2'b11, 1'b0, 1'b0);
    check("R9 restart via write", int'(main_osc_en), 1);
    count_delay(n);
    check("R4 delay after restart", n, 1);
    do_write(2'b00, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R9 stop ignored while busy", int'(main_osc_en), 1);
    check("R9 still busy", int'(busy), 1);
    count_delay(n);
    check("R9 switch completes", int'(cur_div), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main_steps();
    t_illegal();
    t_restart();
    t_sub_path();
    t_stop();
    done = 1;
    finish_run();
  end
endmodule